// File: doc/BRIEF.md
# No-Turnaround Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM. Reads and writes may follow each other in any order on consecutive clocks with no idle cycle between them. Every control, address and byte-enable input is registered on the rising clock edge. Write data trails its command by one enabled clock. Read data appears on the bus one enabled clock after its address was taken. Because a write and a read never occupy the array in the same cycle, the bus is fully used.

A command is either loaded from the pins or continued by an internal 2-bit burst counter. The counter steps through the four words of an aligned group, in linear or interleaved order, and the upper address bits stay fixed for the whole burst. An active-low clock enable freezes the whole block. Three chip selects decide whether a load cycle addresses the device or deselects it. The data bus is split into an input, an output and a drive-enable, which fits an on-chip tri-state or a pad ring.

Top module: `nowait_sram`

## Requirements
- R1: A load cycle is an enabled clock edge with `adv_i` low. At that edge the address, `we_ni`, the byte enables and `mode_i` are captured, and the burst step is reset to 0.
- R2: A load cycle selects the device only if `ce1_i`=1, `ce2_i`=1 and `ce3_ni`=0. If any of these is false, the cycle is a deselect: nothing is written and the bus is not driven for it.
- R3: At an edge where `cke_ni` is high, every input is ignored. Array contents, the pending command, the burst step and the bus outputs keep their values. A pending write takes its data at the next enabled edge.
- R4: At an enabled edge with `adv_i` high, the burst step increments and the previous read or write command continues. Advancing after a deselect stays deselected.
- R5: With the mode captured as 0 (linear), burst address low bits = (start low bits + step) mod 4. Address bits [ADDR_W-1:2] stay fixed.
- R6: With the mode captured as 1 (interleaved), burst address low bits = start low bits XOR step. The upper bits stay fixed.
- R7: A selected cycle with `we_ni` low at its address edge writes the word present on `dq_i` at the next enabled edge.
- R8: Byte enable `bw_ni[i]` is active low and is captured with each address. It controls data bits [9i+8:9i]. Disabled bytes keep their old contents.
- R9: For a read whose address is captured at enabled edge N, `dq_o` carries the stored word after enabled edge N+1.
- R10: Reads and writes run back to back in any order. A read issued on the clock right after a write to the same address returns the newly written data.
- R11: `dq_oe_o` is high only while the last retired cycle was a read and `oe_ni` is low. It is low out of reset, during write and deselect cycles, and whenever `oe_ni` is high.
- R12: The burst order is taken from `mode_i` at the load cycle. A change of `mode_i` during advance cycles does not alter the ongoing burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| ce1_i | input | 1 | Chip select, active high |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| we_ni | input | 1 | 0 = write, 1 = read (on load cycles) |
| bw_ni | input | NUM_BYTES | Byte write enables, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | NUM_BYTES*BYTE_W | Write data, one enabled clock after its command |
| dq_o | output | NUM_BYTES*BYTE_W | Read data |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions are checked on every cycle. They cover the suspend hold of the command register and burst step, the step reset on loads, deselect on a failed chip-select term, the continuation of the command and upper address bits through advances, and the bus enable following read and write retirement. Data correctness depends on the bench's scenarios: linear and interleaved orders from every start offset, mode changes mid-burst, byte-masked writes, read-right-after-write, and suspends placed between a write command and its data. For these, the bench keeps its own model of the array and pipeline and compares the bus with it on every cycle.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burst_mode_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input burst_mode_e mode);
    logic [1:0] r;
    if (mode == BURST_INTERLEAVE) r = start ^ step;
    else                          r = start + step;
    return r;
  endfunction
endpackage

// File: rtl/nsr_ctrl.sv
module nsr_ctrl
  import nsr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 adv_i,
  input  logic                 sel_i,
  input  logic                 we_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic                 mode_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 cmd_valid_o,
  output logic                 cmd_write_o,
  output logic [ADDR_W-1:0]    cmd_addr_o,
  output logic [NUM_BYTES-1:0] cmd_bmask_o
);
  localparam int HI_W = ADDR_W - 2;

  logic                 valid_q, write_q;
  logic [ADDR_W-1:0]    base_q;
  logic [1:0]           step_q;
  burst_mode_e          mode_q;
  logic [NUM_BYTES-1:0] bmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      base_q  <= '0;
      step_q  <= '0;
      mode_q  <= BURST_LINEAR;
      bmask_q <= '0;
    end else if (en_i) begin
      bmask_q <= ~bw_ni;
      if (!adv_i) begin
        valid_q <= sel_i;
        write_q <= ~we_ni;
        base_q  <= addr_i;
        step_q  <= '0;
        mode_q  <= burst_mode_e'(mode_i);
      end else if (valid_q) begin
        step_q  <= step_q + 2'd1;
      end
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_write_o = write_q;
  assign cmd_bmask_o = bmask_q;
  assign cmd_addr_o  = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], step_q, mode_q)};

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(valid_q) && $stable(write_q) && $stable(step_q) && $stable(cmd_addr_o)); // R3
  AST_LOAD_STEP0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !adv_i |=> step_q == 2'd0); // R1
  AST_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !adv_i && !sel_i |=> !cmd_valid_o); // R2
  AST_ADV_CONTINUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i |=> cmd_valid_o == $past(cmd_valid_o) && cmd_write_o == $past(cmd_write_o)); // R4
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && adv_i |=> cmd_addr_o[ADDR_W-1 -: HI_W] == $past(cmd_addr_o[ADDR_W-1 -: HI_W])); // R5
endmodule

// File: rtl/nsr_array.sv
module nsr_array #(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        valid_i,
  input  logic                        write_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BYTES-1:0]        bmask_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic do_wr, do_rd;
  assign do_wr = en_i && valid_i && write_i;
  assign do_rd = en_i && valid_i && !write_i;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (do_wr && bmask_i[g]) lane_mem[addr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rd_q <= '0;
      else if (do_rd) rd_q <= lane_mem[addr_i];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = rd_q;
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o)); // R3
endmodule

// File: rtl/nsr_out.sv
module nsr_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rd_retire_i,
  input  logic oe_ni,
  output logic dq_oe_o
);
  logic drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   drive_q <= 1'b0;
    else if (en_i) drive_q <= rd_retire_i;
  end

  assign dq_oe_o = drive_q & ~oe_ni;
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram #(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_ni,
  input  logic                        ce1_i,
  input  logic                        ce2_i,
  input  logic                        ce3_ni,
  input  logic                        adv_i,
  input  logic                        we_ni,
  input  logic [NUM_BYTES-1:0]        bw_ni,
  input  logic                        mode_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        oe_ni,
  input  logic [NUM_BYTES*BYTE_W-1:0] dq_i,
  output logic [NUM_BYTES*BYTE_W-1:0] dq_o,
  output logic                        dq_oe_o
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic                 en, sel;
  logic                 cmd_valid, cmd_write;
  logic [ADDR_W-1:0]    cmd_addr;
  logic [NUM_BYTES-1:0] cmd_bmask;
  logic [DATA_W-1:0]    rdata;

  assign en  = ~cke_ni;
  assign sel = ce1_i & ce2_i & ~ce3_ni;

  nsr_ctrl #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .en_i(en), .adv_i, .sel_i(sel), .we_ni, .bw_ni, .mode_i, .addr_i,
    .cmd_valid_o(cmd_valid), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_bmask_o(cmd_bmask)
  );

  nsr_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_array (
    .clk_i, .rst_ni, .en_i(en), .valid_i(cmd_valid), .write_i(cmd_write),
    .addr_i(cmd_addr), .bmask_i(cmd_bmask), .wdata_i(dq_i), .rdata_o(rdata)
  );

  nsr_out u_out (
    .clk_i, .rst_ni, .en_i(en), .rd_retire_i(cmd_valid & ~cmd_write),
    .oe_ni, .dq_oe_o
  );

  assign dq_o = rdata;

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && cmd_valid && cmd_write |=> !dq_oe_o); // R11
  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && cmd_valid && !cmd_write |=> dq_oe_o == !oe_ni); // R9
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !cmd_valid |=> !dq_oe_o); // R2
endmodule

// File: tb/tb_nowait_sram.sv
`timescale 1ns/1ps
module tb_nowait_sram;
  localparam int AW = 8, BW = 9, NB = 2, DW = NB * BW;
  localparam bit [2:0] SEL = 3'b110;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke_ni = 1'b0, ce1 = 1'b0, ce2 = 1'b0, ce3_n = 1'b1, adv = 1'b0, we_n = 1'b1, mode = 1'b0, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0, dq_o;
  logic dq_oe;

  always #2.5 clk = ~clk;

  nowait_sram #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) dut (
    .clk_i(clk), .rst_ni, .cke_ni, .ce1_i(ce1), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adv_i(adv), .we_ni(we_n), .bw_ni(bw_n), .mode_i(mode), .addr_i(addr),
    .oe_ni(oe_n), .dq_i, .dq_o, .dq_oe_o(dq_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // bench model
  logic [DW-1:0] exp_mem [1 << AW];
  bit m_valid = 0, m_write = 0, m_mode = 0, m_oe = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_step = '0, m_bw = '0;
  logic [DW-1:0] m_rd = '0;

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = m_mode ? (m_base[1:0] ^ m_step) : 2'(m_base[1:0] + m_step);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  task automatic drive(input bit ck_n, input bit [2:0] ce, input bit a, input bit w_n,
                       input bit [1:0] b_n, input bit md, input bit [AW-1:0] ad, input bit o_n);
    logic [DW-1:0] wd;
    logic [AW-1:0] pa;
    wd = DW'($urandom);
    cke_ni = ck_n; {ce1, ce2, ce3_n} = ce; adv = a; we_n = w_n; bw_n = b_n;
    mode = md; addr = ad; oe_n = o_n; dq_i = wd;
    @(posedge clk);
    @(negedge clk);
    if (!ck_n) begin
      pa = model_addr();
      if (m_valid && m_write) begin
        for (int i = 0; i < NB; i++)
          if (m_bw[i]) exp_mem[pa][i*BW +: BW] = wd[i*BW +: BW];
      end
      m_oe = m_valid && !m_write;
      if (m_oe) m_rd = exp_mem[pa];
      m_bw = ~b_n;
      if (!a) begin
        m_valid = (ce == SEL); m_write = !w_n; m_base = ad; m_step = 0; m_mode = md;
      end else if (m_valid) m_step = m_step + 2'd1;
    end
    chk(dq_oe === (m_oe && !o_n), (ck_n || o_n) ? tag : "R11", {17'd0, dq_oe}, {17'd0, m_oe && !o_n});
    if (m_oe && !o_n) chk(dq_o === m_rd, tag, dq_o, m_rd);
  endtask

  task automatic burst(input bit w_n, input bit md, input bit [AW-1:0] a0, input bit [1:0] b_n);
    drive(0, SEL, 0, w_n, b_n, md, a0, 0);
    for (int k = 0; k < 3; k++) drive(0, SEL, 1, 1, b_n, md, 8'($urandom), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    chk(dq_oe === 1'b0, "R11 reset", {17'd0, dq_oe}, '0);

    // R7: fill array with single-word writes back to back
    tag = "R7";
    for (int a = 0; a < 256; a++) drive(0, SEL, 0, 0, 2'b00, 0, 8'(a), 0);

    // R9: isolated single reads, deselect between
    tag = "R9";
    for (int a = 0; a < 32; a++) begin
      drive(0, SEL, 0, 1, 2'b11, 0, 8'(a * 7), 0);
      drive(0, 3'b000, 0, 1, 2'b11, 0, 8'(a), 0);
    end

    // R5: linear read bursts from every start offset
    tag = "R5";
    for (int g = 0; g < 64; g++) burst(1, 0, 8'(g * 4 + (g % 4)), 2'b11);

    // R6: interleaved read bursts from every start offset
    tag = "R6";
    for (int g = 0; g < 64; g++) burst(1, 1, 8'(g * 4 + ((g + 1) % 4)), 2'b11);

    // R12: mode pin toggles during advance cycles
    tag = "R12";
    for (int g = 0; g < 16; g++) begin
      drive(0, SEL, 0, 1, 2'b11, g[0], 8'(g * 12 + 1), 0);
      for (int k = 0; k < 3; k++) drive(0, SEL, 1, 1, 2'b11, ~g[0], 8'(k), 0);
    end

    // R8: byte-masked write bursts then read back
    tag = "R8";
    for (int g = 0; g < 16; g++) begin
      drive(0, SEL, 0, 0, 2'(g), g[1], 8'(g * 16 + 2), 0);
      for (int k = 0; k < 3; k++) drive(0, SEL, 1, 1, 2'(g + k + 1), 0, 8'(k), 0);
      burst(1, g[1], 8'(g * 16 + 2), 2'b11);
    end

    // R4: write burst continuation, advance after deselect
    tag = "R4";
    for (int g = 0; g < 8; g++) begin
      burst(0, g[0], 8'(g * 4 + 200), 2'b00);
      drive(0, 3'b100, 0, 0, 2'b00, 0, 8'(g * 4 + 200), 0);
      for (int k = 0; k < 3; k++) drive(0, SEL, 1, 0, 2'b00, 0, 8'(k), 0);
      burst(1, g[0], 8'(g * 4 + 200), 2'b11);
    end

    // R2: each chip-select term alone deselects, even as a write
    tag = "R2";
    for (int g = 0; g < 12; g++) begin
      drive(0, (g % 3 == 0) ? 3'b010 : (g % 3 == 1) ? 3'b100 : 3'b111, 0, 0, 2'b00, 0, 8'(g + 40), 0);
      drive(0, SEL, 0, 1, 2'b11, 0, 8'(g + 40), 0);
      drive(0, SEL, 0, 1, 2'b11, 0, 8'(g + 41), 0);
    end

    // R10: alternate write and read of the same address each clock
    tag = "R10";
    for (int g = 0; g < 64; g++) begin
      drive(0, SEL, 0, 0, 2'b00, 0, 8'(g * 3), 0);
      drive(0, SEL, 0, 1, 2'b11, 0, 8'(g * 3), 0);
    end

    // R1: new loads every clock with random controls, always selected
    tag = "R1";
    for (int g = 0; g < 400; g++)
      drive(0, SEL, 0, 1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 0);

    // R3: suspends inside bursts and between write command and data
    tag = "R3";
    for (int g = 0; g < 1500; g++)
      drive(($urandom % 3) == 0, (($urandom % 6) == 0) ? 3'b011 : SEL, 1'($urandom),
            1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 0);

    // R11: output enable gating with random traffic
    tag = "R11";
    for (int g = 0; g < 1500; g++)
      drive(($urandom % 5) == 0, SEL, 1'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), 8'($urandom), 1'($urandom));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule